// File: doc/BRIEF.md
# Bounded Counting Semaphore Bank

This block holds eight small counting semaphores. The execution threads of one processing tile use them to hand work to each other. Each semaphore has a 4-bit count and a 4-bit ceiling, and both are cleared by reset.

A command port carries 32-bit command words. The top byte of each word selects the operation, and a bitmask selects the semaphores it acts on. An init command clears the count and loads a new ceiling. A post command raises the count, but never above the ceiling. A get command lowers the count, but never below zero. A wait command holds the command port: the next command is not accepted until the chosen semaphores leave the requested condition, which keeps each thread's commands in program order.

A second port is a word-addressed register window. It accepts requests only from a fixed set of requester IDs. Through it an allowed requester can read a count, or post or get one directly. A window post is capped at 15 instead of the programmed ceiling.

Top module: `sem_bank`

## Requirements
- R1: After reset every count and every ceiling is 0, `cmd_ready` is 1, `win_rdata` is 0, and a window read of any semaphore returns 0.
- R2: A command whose top byte is 0x8C or 0xA3 is an init. For every semaphore n whose word bit n+2 is set, the count becomes 0 and the ceiling is loaded from word bits [23:20].
- R3: A command with top byte 0x90 raises the count of each selected semaphore by one. A semaphore whose count is already at or above its ceiling keeps its count.
- R4: A command with top byte 0x94 lowers the count of each selected semaphore by one. A count of 0 stays at 0.
- R5: A command with top byte 0x98 is a wait, and word bits [17:16] give the condition. Bit 16 means "stall while a selected count is 0". Bit 17 means "stall while a selected count is at or above its ceiling". If the condition holds when the wait is accepted, `cmd_ready` goes low in the next cycle. If it does not hold, `cmd_ready` stays high.
- R6: While a wait is stalled, no command is accepted. `cmd_ready` returns to 1 in the cycle after the first cycle in which the stored counts no longer meet the condition. A held command is then accepted in order.
- R7: A window read at byte offset 0x20+4*i returns count i, zero-extended, on `win_rdata` one cycle later. Any other offset, and any cycle without a read, gives 0.
- R8: A window write at offset 0x20+4*i acts on count i according to data bit 0. A value of 0 posts, capped at 15 whatever the ceiling is. A value of 1 gets, floored at 0.
- R9: Only requester IDs 2, 3 and 4 may use the window. Writes from any other ID have no effect, and reads from them return 0.
- R10: When a command post or get and a window post or get reach the same semaphore in the same cycle, their net change is applied. A rise is capped at the ceiling when a command post takes part, and at 15 otherwise. A fall is floored at 0.
- R11: An init wins over a window write to the same semaphore in the same cycle.
- R12: A command with any other top byte is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command word is present |
| cmd_word | input | 32 | Command: opcode [31:24], ceiling [23:20], wait condition [17:16], semaphore mask [9:2] |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid`; low while a wait is stalled |
| win_valid | input | 1 | Window access in this cycle |
| win_write | input | 1 | 1 = write, 0 = read |
| win_id | input | 3 | Requester ID |
| win_addr | input | 8 | Byte offset within the window |
| win_wdata | input | 32 | Write data; only bit 0 is used |
| win_rdata | output | 32 | Read data, registered, valid in the cycle after the read |

## Verification
The checker watches every cycle for four things: the single steps of command post and get, the values an init loads, the stall that starts after a blocking wait, and the silence of the window toward requesters that are not allowed. Some behaviour only shows across several cycles, and only the bench scenarios reveal it. That covers the exact cycle in which a wait is released, the order of a command held behind a stall, net changes when both ports act at once, and the precedence of an init. The bench carries a behavioural model of the counts and compares `cmd_ready` and `win_rdata` against it on every cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [2:0] {
    SOP_NONE,
    SOP_INIT,
    SOP_POST,
    SOP_GET,
    SOP_WAIT
  } sem_op_e;

  localparam logic [7:0] OPC_INIT_A = 8'h8C;
  localparam logic [7:0] OPC_INIT_B = 8'hA3;
  localparam logic [7:0] OPC_POST   = 8'h90;
  localparam logic [7:0] OPC_GET    = 8'h94;
  localparam logic [7:0] OPC_WAIT   = 8'h98;

  localparam int SEL_LSB  = 2;
  localparam int COND_LSB = 16;
  localparam int CEIL_LSB = 20;
  localparam int OPC_LSB  = 24;

  function automatic sem_op_e decode_opc(input logic [7:0] opc);
    case (opc)
      OPC_INIT_A, OPC_INIT_B: decode_opc = SOP_INIT;
      OPC_POST:               decode_opc = SOP_POST;
      OPC_GET:                decode_opc = SOP_GET;
      OPC_WAIT:               decode_opc = SOP_WAIT;
      default:                decode_opc = SOP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sem_cmd_decode.sv
module sem_cmd_decode
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int VAL_W   = 4
) (
  input  logic               fire_i,
  input  logic [31:0]        word_i,
  output logic [NUM_SEM-1:0] init_o,
  output logic [NUM_SEM-1:0] up_o,
  output logic [NUM_SEM-1:0] dn_o,
  output logic               wait_o,
  output logic [NUM_SEM-1:0] sel_o,
  output logic [1:0]         cond_o,
  output logic [VAL_W-1:0]   ceil_o
);

  sem_op_e op;

  always_comb begin
    op     = fire_i ? decode_opc(word_i[OPC_LSB +: 8]) : SOP_NONE;
    sel_o  = word_i[SEL_LSB +: NUM_SEM];
    cond_o = word_i[COND_LSB +: 2];
    ceil_o = word_i[CEIL_LSB +: VAL_W];
    init_o = (op == SOP_INIT) ? sel_o : '0;
    up_o   = (op == SOP_POST) ? sel_o : '0;
    dn_o   = (op == SOP_GET)  ? sel_o : '0;
    wait_o = (op == SOP_WAIT);
  end

endmodule

// File: rtl/sem_win_decode.sv
module sem_win_decode #(
  parameter int                NUM_SEM    = 8,
  parameter int                ID_W       = 3,
  parameter int                ADDR_W     = 8,
  parameter logic [2**ID_W-1:0] ALLOW_MASK = 8'b0001_1100,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 8'h20
) (
  input  logic                       valid_i,
  input  logic                       write_i,
  input  logic [ID_W-1:0]            id_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       bit0_i,
  output logic                       rd_hit_o,
  output logic [$clog2(NUM_SEM)-1:0] rd_idx_o,
  output logic [NUM_SEM-1:0]         up_o,
  output logic [NUM_SEM-1:0]         dn_o
);

  localparam int                IDX_W    = $clog2(NUM_SEM);
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(4 * (NUM_SEM - 1));

  logic              in_range;
  logic              hit;
  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel      = addr_i - WIN_BASE;
    in_range = (addr_i >= WIN_BASE) && (addr_i <= WIN_LAST) && (addr_i[1:0] == 2'b00);
    hit      = valid_i && ALLOW_MASK[id_i] && in_range;
    rd_hit_o = hit && !write_i;
    rd_idx_o = rel[2 +: IDX_W];
    up_o     = '0;
    dn_o     = '0;
    if (hit && write_i) begin
      up_o[rd_idx_o] = !bit0_i;
      dn_o[rd_idx_o] = bit0_i;
    end
  end

endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int VAL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic [VAL_W-1:0] init_ceil_i,
  input  logic             cmd_up_i,
  input  logic             cmd_dn_i,
  input  logic             win_up_i,
  input  logic             win_dn_i,
  output logic [VAL_W-1:0] val_o,
  output logic [VAL_W-1:0] ceil_o
);

  localparam int               SUM_W = VAL_W + 2;
  localparam logic [VAL_W-1:0] FULL  = '1;

  logic [VAL_W-1:0]        val_q, val_d, ceil_q, ceil_d, lim;
  logic signed [SUM_W-1:0] ups, dns, sum;
  logic                    en;

  always_comb begin
    ups    = $signed(SUM_W'(cmd_up_i)) + $signed(SUM_W'(win_up_i));
    dns    = $signed(SUM_W'(cmd_dn_i)) + $signed(SUM_W'(win_dn_i));
    sum    = $signed({2'b00, val_q}) + ups - dns;
    lim    = cmd_up_i ? ceil_q : FULL;
    val_d  = val_q;
    ceil_d = ceil_q;
    en     = init_i || (ups != dns);
    if (init_i) begin
      val_d  = '0;
      ceil_d = init_ceil_i;
    end else if (ups > dns) begin
      if (val_q >= lim)                       val_d = val_q;
      else if (sum > $signed({2'b00, lim}))   val_d = lim;
      else                                    val_d = sum[VAL_W-1:0];
    end else if (dns > ups) begin
      val_d = (sum < 0) ? '0 : sum[VAL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      ceil_q <= '0;
    end else if (en) begin
      val_q  <= val_d;
      ceil_q <= ceil_d;
    end
  end

  assign val_o  = val_q;
  assign ceil_o = ceil_q;

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int                 NUM_SEM    = 8,
  parameter int                 VAL_W      = 4,
  parameter int                 ID_W       = 3,
  parameter int                 ADDR_W     = 8,
  parameter logic [2**ID_W-1:0] ALLOW_MASK = 8'b0001_1100,
  parameter logic [ADDR_W-1:0]  WIN_BASE   = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_word,
  output logic              cmd_ready,
  input  logic              win_valid,
  input  logic              win_write,
  input  logic [ID_W-1:0]   win_id,
  input  logic [ADDR_W-1:0] win_addr,
  input  logic [31:0]       win_wdata,
  output logic [31:0]       win_rdata
);

  localparam int IDX_W = $clog2(NUM_SEM);

  logic                            rst_meta, srst_n;
  logic                            cmd_fire;
  logic [NUM_SEM-1:0]              c_init, c_up, c_dn, c_sel, w_up, w_dn;
  logic                            c_wait;
  logic [1:0]                      c_cond;
  logic [VAL_W-1:0]                c_ceil;
  logic                            rd_hit;
  logic [IDX_W-1:0]                rd_idx;
  logic [NUM_SEM-1:0][VAL_W-1:0]   val_all, ceil_all;
  logic                            pend_q, pend_d, arm_en;
  logic [NUM_SEM-1:0]              wmask_q;
  logic [1:0]                      wcond_q;
  logic                            new_blocks, old_blocks;
  logic [31:0]                     rdata_d;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  assign cmd_ready = !pend_q;
  assign cmd_fire  = cmd_valid && cmd_ready;

  sem_cmd_decode #(.NUM_SEM(NUM_SEM), .VAL_W(VAL_W)) u_cdec (
    .fire_i(cmd_fire), .word_i(cmd_word), .init_o(c_init), .up_o(c_up),
    .dn_o(c_dn), .wait_o(c_wait), .sel_o(c_sel), .cond_o(c_cond), .ceil_o(c_ceil)
  );

  sem_win_decode #(.NUM_SEM(NUM_SEM), .ID_W(ID_W), .ADDR_W(ADDR_W),
                   .ALLOW_MASK(ALLOW_MASK), .WIN_BASE(WIN_BASE)) u_wdec (
    .valid_i(win_valid), .write_i(win_write), .id_i(win_id), .addr_i(win_addr),
    .bit0_i(win_wdata[0]), .rd_hit_o(rd_hit), .rd_idx_o(rd_idx), .up_o(w_up), .dn_o(w_dn)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
    sem_cell #(.VAL_W(VAL_W)) u_cell (
      .clk(clk), .rst_n(srst_n), .init_i(c_init[g]), .init_ceil_i(c_ceil),
      .cmd_up_i(c_up[g]), .cmd_dn_i(c_dn[g]), .win_up_i(w_up[g]), .win_dn_i(w_dn[g]),
      .val_o(val_all[g]), .ceil_o(ceil_all[g])
    );
  end

  // wait condition against the stored counts
  always_comb begin
    new_blocks = 1'b0;
    old_blocks = 1'b0;
    for (int i = 0; i < NUM_SEM; i++) begin
      if (c_sel[i] && ((c_cond[0] && val_all[i] == '0) ||
                       (c_cond[1] && val_all[i] >= ceil_all[i])))
        new_blocks = 1'b1;
      if (wmask_q[i] && ((wcond_q[0] && val_all[i] == '0) ||
                         (wcond_q[1] && val_all[i] >= ceil_all[i])))
        old_blocks = 1'b1;
    end
    arm_en = c_wait && new_blocks;
    pend_d = pend_q ? old_blocks : arm_en;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wmask_q <= '0;
      wcond_q <= '0;
    end else if (arm_en) begin
      wmask_q <= c_sel;
      wcond_q <= c_cond;
    end
  end

  always_comb rdata_d = rd_hit ? 32'(val_all[rd_idx]) : 32'd0;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) win_rdata <= '0;
    else         win_rdata <= rdata_d;
  end

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int                 NUM_SEM    = 8,
  parameter int                 VAL_W      = 4,
  parameter int                 ID_W       = 3,
  parameter int                 ADDR_W     = 8,
  parameter logic [2**ID_W-1:0] ALLOW_MASK = 8'b0001_1100
) (
  input logic                          clk,
  input logic                          srst_n,
  input logic                          cmd_valid,
  input logic                          cmd_ready,
  input logic [31:0]                   cmd_word,
  input logic                          win_valid,
  input logic                          win_write,
  input logic [ID_W-1:0]               win_id,
  input logic [31:0]                   win_rdata,
  input logic [NUM_SEM-1:0][VAL_W-1:0] val_all,
  input logic [NUM_SEM-1:0][VAL_W-1:0] ceil_all
);

  logic       fire;
  logic [7:0] opc;
  assign fire = cmd_valid && cmd_ready;
  assign opc  = cmd_word[31:24];

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
    AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!srst_n)
      fire && (opc == 8'h8C || opc == 8'hA3) && cmd_word[i+2]
      |=> val_all[i] == '0 && ceil_all[i] == $past(cmd_word[20 +: VAL_W])); // R2
    AST_POST_STEP: assert property (@(posedge clk) disable iff (!srst_n)
      fire && opc == 8'h90 && cmd_word[i+2] && !win_valid && val_all[i] < ceil_all[i]
      |=> val_all[i] == VAL_W'($past(val_all[i]) + 1'b1)); // R3
    AST_GET_STEP: assert property (@(posedge clk) disable iff (!srst_n)
      fire && opc == 8'h94 && cmd_word[i+2] && !win_valid && val_all[i] != '0
      |=> val_all[i] == VAL_W'($past(val_all[i]) - 1'b1)); // R4
    AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!srst_n)
      fire && opc == 8'h98 && cmd_word[16] && cmd_word[i+2] && val_all[i] == '0
      |=> !cmd_ready); // R5
  end

  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    win_valid && win_write && !ALLOW_MASK[win_id] && !fire |=> $stable(val_all)); // R9
  AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (!srst_n)
    win_valid && !win_write && !ALLOW_MASK[win_id] |=> win_rdata == 32'd0); // R9

endmodule

bind sem_bank sem_bank_chk #(
  .NUM_SEM(NUM_SEM), .VAL_W(VAL_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .ALLOW_MASK(ALLOW_MASK)
) u_chk (
  .clk(clk), .srst_n(srst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_word(cmd_word), .win_valid(win_valid), .win_write(win_write), .win_id(win_id),
  .win_rdata(win_rdata), .val_all(val_all), .ceil_all(ceil_all)
);

// File: tb/test_sem_bank.sv
module test_sem_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_ready;
  logic        win_valid = 1'b0;
  logic        win_write = 1'b0;
  logic [2:0]  win_id = '0;
  logic [7:0]  win_addr = '0;
  logic [31:0] win_wdata = '0;
  logic [31:0] win_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  sem_bank i_sem_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .win_valid(win_valid), .win_write(win_write),
    .win_id(win_id), .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int mv[8];
  int mm[8];
  bit mpend;
  int mmask, mcond, mrd;

  function automatic bit allowed(int id);
    return id == 2 || id == 3 || id == 4;
  endfunction

  function automatic bit blocks(int mask, int cond);
    for (int i = 0; i < 8; i++)
      if (mask[i] && (((cond & 1) != 0 && mv[i] == 0) || ((cond & 2) != 0 && mv[i] >= mm[i])))
        return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin mv[i] = 0; mm[i] = 0; end
      mpend = 0; mmask = 0; mcond = 0; mrd = 0;
    end else begin
      bit acc;
      int op, sel, widx, nrd;
      bit whit;
      acc  = cmd_valid && !mpend;
      op   = cmd_word[31:24];
      sel  = cmd_word[9:2];
      whit = win_valid && allowed(win_id) && win_addr >= 8'h20 && win_addr <= 8'h3C
             && win_addr[1:0] == 2'b00;
      widx = (win_addr - 8'h20) / 4;
      nrd  = (whit && !win_write) ? mv[widx] : 0;
      if (mpend) begin
        if (!blocks(mmask, mcond)) mpend = 0;
      end else if (acc && op == 8'h98) begin
        if (blocks(sel, cmd_word[17:16])) begin
          mpend = 1; mmask = sel; mcond = cmd_word[17:16];
        end
      end
      for (int i = 0; i < 8; i++) begin
        int cu, cd, wu, wd, net, lim;
        cu = (acc && op == 8'h90 && sel[i]) ? 1 : 0;
        cd = (acc && op == 8'h94 && sel[i]) ? 1 : 0;
        wu = (whit && win_write && widx == i && !win_wdata[0]) ? 1 : 0;
        wd = (whit && win_write && widx == i &&  win_wdata[0]) ? 1 : 0;
        if (acc && (op == 8'h8C || op == 8'hA3) && sel[i]) begin
          mv[i] = 0; mm[i] = cmd_word[23:20];
        end else begin
          net = cu + wu - cd - wd;
          lim = (cu != 0) ? mm[i] : 15;
          if (net > 0 && mv[i] < lim) mv[i] = (mv[i] + net > lim) ? lim : mv[i] + net;
          else if (net < 0) mv[i] = (mv[i] + net < 0) ? 0 : mv[i] + net;
        end
      end
      mrd = nrd;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_cmp++;
      if (cmd_ready !== !mpend) begin
        n_bad++;
        $display("FAIL R6 cmd_ready act=%0b exp=%0b t=%0t", cmd_ready, !mpend, $time);
      end
      n_cmp++;
      if (win_rdata !== 32'(mrd)) begin
        n_bad++;
        $display("FAIL R7 win_rdata act=%0d exp=%0d t=%0t", win_rdata, mrd, $time);
      end
    end
  end

  // ---------------- helpers (all start and end at a falling edge) ----------------
  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(logic [31:0] w);
    cmd_valid = 1'b1; cmd_word = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wwr(int id, int idx, bit b0);
    win_valid = 1'b1; win_write = 1'b1; win_id = 3'(id);
    win_addr = 8'(8'h20 + 4 * idx); win_wdata = {31'd0, b0};
    @(negedge clk);
    win_valid = 1'b0; win_write = 1'b0;
  endtask

  task automatic rd_raw(int id, int addr, output int v);
    win_valid = 1'b1; win_write = 1'b0; win_id = 3'(id); win_addr = 8'(addr);
    @(negedge clk);
    win_valid = 1'b0;
    v = int'(win_rdata);
  endtask

  task automatic rd_chk(string tag, int idx, int exp);
    int v;
    rd_raw(2, 8'h20 + 4 * idx, v);
    chk(tag, v, exp);
  endtask

  task automatic both(logic [31:0] w, int idx, bit b0);
    cmd_valid = 1'b1; cmd_word = w;
    win_valid = 1'b1; win_write = 1'b1; win_id = 3'd3;
    win_addr = 8'(8'h20 + 4 * idx); win_wdata = {31'd0, b0};
    @(negedge clk);
    cmd_valid = 1'b0; win_valid = 1'b0; win_write = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1: reset state
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 rdata", int'(win_rdata), 0);
    for (int i = 0; i < 8; i++) rd_chk("R1 count", i, 0);

    // R2: init sem0..3 ceiling 3 (opcode 0x8C), sem4 ceiling 15 (opcode 0xA3)
    cmd(32'h8C30_003C);
    cmd(32'hA3F0_0040);
    rd_chk("R2 init count", 0, 0);

    // R3: five posts on sem0 stop at ceiling 3
    for (int k = 0; k < 5; k++) cmd(32'h9000_0004);
    rd_chk("R3 post cap", 0, 3);
    cmd(32'h9000_0040);
    rd_chk("R3 post sem4", 4, 1);

    // R4: get at zero stays zero, then post/post/get
    cmd(32'h9400_0008);
    rd_chk("R4 floor", 1, 0);
    cmd(32'h9000_0008); cmd(32'h9000_0008); cmd(32'h9400_0008);
    rd_chk("R4 step", 1, 1);

    // R8: window post ignores ceiling 0, caps at 15; window get
    for (int k = 0; k < 17; k++) wwr(2, 6, 1'b0);
    rd_chk("R8 cap15", 6, 15);
    wwr(3, 6, 1'b1); wwr(3, 6, 1'b1);
    rd_chk("R8 get", 6, 13);
    wwr(4, 7, 1'b1);
    rd_chk("R8 floor", 7, 0);

    // R9: foreign requester
    wwr(0, 7, 1'b0);
    rd_chk("R9 foreign write", 7, 0);
    rd_raw(1, 8'h38, v);
    chk("R9 foreign read", v, 0);

    // R7: offsets outside the window
    rd_raw(2, 8'h40, v); chk("R7 above", v, 0);
    rd_raw(2, 8'h1C, v); chk("R7 below", v, 0);
    rd_raw(2, 8'h3A, v); chk("R7 unaligned", v, 0);
    rd_raw(2, 8'h38, v); chk("R7 sem6", v, 13);

    // R5/R6: wait while sem2 is zero, released by a window post
    fork
      cmd(32'h9801_0010);
      begin
        repeat (3) @(negedge clk);
        chk("R5 stalled", int'(cmd_ready), 0);
        wwr(2, 2, 1'b0);
      end
    join
    chk("R6 still stalled", int'(cmd_ready), 0);
    @(negedge clk);
    chk("R6 released", int'(cmd_ready), 1);

    // R6: wait on sem0 at ceiling; a post on sem2 is held behind it
    fork
      begin
        cmd(32'h9802_0004);
        cmd(32'h9000_0010);
      end
      begin
        repeat (4) @(negedge clk);
        rd_chk("R6 held post", 2, 1);
        wwr(3, 0, 1'b1);
      end
    join
    rd_chk("R6 ordered post", 2, 2);

    // R5: a wait whose condition is already false does not stall
    cmd(32'h9801_0004);
    chk("R5 no stall", int'(cmd_ready), 1);

    // R12: unknown opcode
    cmd(32'h5500_003C);
    rd_chk("R12 no effect", 0, 2);

    // R10: concurrent command and window on sem3 (ceiling 3)
    cmd(32'h9000_0020); cmd(32'h9000_0020);
    both(32'h9000_0020, 3, 1'b1);
    rd_chk("R10 up+down", 3, 2);
    both(32'h9400_0020, 3, 1'b1);
    rd_chk("R10 down+down", 3, 0);
    both(32'h9000_0020, 3, 1'b0);
    both(32'h9000_0020, 3, 1'b0);
    rd_chk("R10 up+up cap", 3, 3);

    // R11: init beats a window post in the same cycle
    both(32'h8C50_0008, 1, 1'b0);
    rd_chk("R11 init wins", 1, 0);
    for (int k = 0; k < 6; k++) cmd(32'h9000_0008);
    rd_chk("R11 new ceiling", 1, 5);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule